// File: doc/BRIEF.md
# Data-Stationary Five-Stage Pipeline Controller

This block steers a five-stage in-order integer pipeline (fetch, decode/register read, execute, memory, writeback). It owns the program counter and decodes every instruction exactly once, in the decode stage. The resulting control word then travels down a chain of stage registers beside the instruction, so each stage drives its strobes only from the control word it currently holds. The ALU, the instruction and data memories and the register-file storage sit outside the block and see only its control outputs.

Every instruction class uses the register-file write port in stage 5. Register-to-register ALU instructions pass through the memory stage without acting there. Conditional branches are resolved in the execute stage from an equality flag that the datapath supplies. The one instruction after a branch (the delay slot) always completes. When the branch is taken, the next instruction, which has already been fetched, is turned into a bubble: it keeps its place in the pipe but has every side effect cleared.

Top module: `dstat_pipe_ctl`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `pc_o` equals `RESET_PC`. In the same cycles `rf_we_o`, `dmem_rd_o`, `dmem_wr_o`, `pc_sel_o`, `ex_ovf_en_o` and `id_squash_o` are all 0.
- R2: When no taken branch sits in the execute stage, `pc_o` advances by 4 at each clock edge.
- R3: The instruction word is decoded with bits [31:26] as the class code, [25:21] as source A, [20:16] as source B, [15:11] as the register-class destination, [5:0] as the function code and [15:0] as the offset or immediate. `rf_ra_o` and `rf_rb_o` show the source fields of the instruction in decode. The instruction in execute drives `ex_alu_op_o` with 0=add, 1=subtract, 2=and, 3=or, and drives `ex_use_imm_o`. Class 0x00 uses function 0x20 add (overflow checked), 0x21 add (unchecked), 0x22 subtract (overflow checked), 0x24 and, and 0x25 or. Class 0x08 is add-immediate with overflow checked. For an overflow-checked instruction that is not squashed, `ex_ovf_en_o` is 1 in execute.
- R4: A register-class or add-immediate instruction fetched in cycle t asserts `rf_we_o` in cycle t+4, with its destination on `rf_waddr_o`. It never asserts a data-memory strobe.
- R5: A load (class 0x23, destination in [20:16]) asserts `dmem_rd_o` in cycle t+3. In cycle t+4 it asserts `rf_we_o` and `wb_sel_mem_o`.
- R6: A store (class 0x2B) asserts `dmem_wr_o` in cycle t+3 and never asserts `rf_we_o`.
- R7: A branch-equal (class 0x04) asserts `pc_sel_o` in cycle t+2 exactly when `br_eq_i` is 1 in that cycle.
- R8: After a taken branch, `pc_o` equals the branch's own PC + 4 + (sign-extended offset × 4).
- R9: The instruction right after a branch (the delay slot) completes normally, whether or not the branch is taken.
- R10: The second instruction after a taken branch is squashed. It asserts no register write, no memory strobe, no overflow enable and no branch.
- R11: `id_squash_o` is 1 in exactly the cycle after `pc_sel_o`, while the squashed instruction sits in decode.
- R12: With `ZERO_REG_FIXED`=1 (the default), a write whose destination is register 0 asserts no `rf_we_o`.
- R13: Any class code, or any class-0x00 function code, not listed above produces no write, memory strobe, overflow enable or branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| br_eq_i | input | 1 | Operand equality flag from the execute stage |
| pc_o | output | PC_W | Fetch address |
| rf_ra_o | output | 5 | Register read address A (decode stage) |
| rf_rb_o | output | 5 | Register read address B (decode stage) |
| id_squash_o | output | 1 | Instruction in decode is a squashed bubble |
| ex_alu_op_o | output | 2 | ALU operation for the execute stage |
| ex_use_imm_o | output | 1 | ALU operand B is the immediate |
| ex_ovf_en_o | output | 1 | Overflow trap enabled in execute |
| pc_sel_o | output | 1 | Load the branch target into the PC |
| dmem_rd_o | output | 1 | Data-memory read strobe (memory stage) |
| dmem_wr_o | output | 1 | Data-memory write strobe (memory stage) |
| rf_we_o | output | 1 | Register-file write enable (writeback stage) |
| rf_waddr_o | output | 5 | Register-file write address |
| wb_sel_mem_o | output | 1 | Writeback data comes from memory |

## Verification
The risky overlap comes from a taken branch. In the same cycle, the branch asserts `pc_sel_o` and redirects the PC, its delay slot is decoded, and the shadow instruction being fetched must be marked for squashing. Meanwhile older instructions are still driving memory and writeback strobes. The bench provokes this with a program that puts branches, overflow-checked writes, loads and further branches in the delay slot and shadow positions. The equality flag follows a mixed pattern, then is held high, then is held low. A behavioural model of in-flight instructions predicts every output each cycle, so a squash that leaks a write, or a redirect that drops the delay slot, shows up as a mismatch.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   localparam int RA_W = 5;
   localparam int IW   = 32;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_AND = 2'd2,
      ALU_OR  = 2'd3
   } alu_op_e;

   localparam logic [5:0] CLS_REG   = 6'h00;
   localparam logic [5:0] CLS_ADDI  = 6'h08;
   localparam logic [5:0] CLS_LOAD  = 6'h23;
   localparam logic [5:0] CLS_STORE = 6'h2B;
   localparam logic [5:0] CLS_BEQ   = 6'h04;

   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_ADDU = 6'h21;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;

   typedef struct packed {
      logic            vld;
      logic            rf_we;
      logic [RA_W-1:0] dst;
      logic            mem_rd;
      logic            mem_wr;
      alu_op_e         alu;
      logic            use_imm;
      logic            ovf_en;
      logic            is_br;
      logic [15:0]     off;
   } ctl_t;

endpackage

// File: rtl/dsc_fetch.sv
module dsc_fetch #(
   parameter int              PC_W     = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [dsc_pkg::IW-1:0] instr_i,
   input  logic                   redirect_i,
   input  logic [PC_W-1:0]        target_i,
   output logic [PC_W-1:0]        pc_o,
   output logic                   fd_vld_o,
   output logic [dsc_pkg::IW-1:0] fd_instr_o,
   output logic [PC_W-1:0]        fd_pc_o,
   output logic                   fd_kill_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(4);

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= RESET_PC;
         fd_vld_o   <= 1'b0;
         fd_instr_o <= '0;
         fd_pc_o    <= '0;
         fd_kill_o  <= 1'b0;
      end else begin
         pc_q       <= redirect_i ? target_i : pc_q + STEP;
         fd_vld_o   <= 1'b1;
         fd_instr_o <= instr_i;
         fd_pc_o    <= pc_q;
         // the word fetched while a taken branch resolves is the shadow
         fd_kill_o  <= redirect_i;
      end
   end

   assign pc_o = pc_q;

   // R2: sequential fetch without redirect
   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_i |=> pc_q == $past(pc_q) + STEP);

   // R8: redirect loads the supplied target
   p_pc_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_i |=> pc_q == $past(target_i));

endmodule

// File: rtl/dsc_decode.sv
module dsc_decode #(
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic                   vld_i,
   input  logic                   kill_i,
   input  logic [dsc_pkg::IW-1:0] instr_i,
   output dsc_pkg::ctl_t          ctl_o
);
   import dsc_pkg::*;

   logic [5:0]      cls;
   logic [5:0]      fn;
   logic [RA_W-1:0] f_rt;
   logic [RA_W-1:0] f_rd;
   ctl_t            raw;
   logic            dst_ok;

   assign cls  = instr_i[31:26];
   assign fn   = instr_i[5:0];
   assign f_rt = instr_i[20:16];
   assign f_rd = instr_i[15:11];

   always_comb begin
      raw     = '0;
      raw.off = instr_i[15:0];
      if (vld_i) begin
         raw.vld = 1'b1;
         unique case (cls)
            CLS_REG: begin
               raw.dst = f_rd;
               unique case (fn)
                  FN_ADD:  begin raw.rf_we = 1'b1; raw.alu = ALU_ADD; raw.ovf_en = 1'b1; end
                  FN_ADDU: begin raw.rf_we = 1'b1; raw.alu = ALU_ADD; end
                  FN_SUB:  begin raw.rf_we = 1'b1; raw.alu = ALU_SUB; raw.ovf_en = 1'b1; end
                  FN_AND:  begin raw.rf_we = 1'b1; raw.alu = ALU_AND; end
                  FN_OR:   begin raw.rf_we = 1'b1; raw.alu = ALU_OR;  end
                  default: ;
               endcase
            end
            CLS_ADDI: begin
               raw.rf_we = 1'b1; raw.dst = f_rt; raw.alu = ALU_ADD;
               raw.use_imm = 1'b1; raw.ovf_en = 1'b1;
            end
            CLS_LOAD: begin
               raw.rf_we = 1'b1; raw.dst = f_rt; raw.mem_rd = 1'b1;
               raw.alu = ALU_ADD; raw.use_imm = 1'b1;
            end
            CLS_STORE: begin
               raw.mem_wr = 1'b1; raw.alu = ALU_ADD; raw.use_imm = 1'b1;
            end
            CLS_BEQ: begin
               raw.is_br = 1'b1; raw.alu = ALU_SUB;
            end
            default: ;
         endcase
         // squashed shadow: stays as a bubble with no side effects
         if (kill_i) begin
            raw.rf_we  = 1'b0;
            raw.mem_rd = 1'b0;
            raw.mem_wr = 1'b0;
            raw.ovf_en = 1'b0;
            raw.is_br  = 1'b0;
         end
      end
   end

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         assign dst_ok = |raw.dst;
      end else begin : g_zero_plain
         assign dst_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      ctl_o       = raw;
      ctl_o.rf_we = raw.rf_we & dst_ok;
   end

endmodule

// File: rtl/dsc_stages.sv
module dsc_stages #(
   parameter int PC_W           = 32,
   parameter bit ZERO_REG_FIXED = 1'b1,
   parameter int N_STG          = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  dsc_pkg::ctl_t                 id_ctl_i,
   input  logic [PC_W-1:0]               id_pc_i,
   input  logic                          br_eq_i,
   output logic [1:0]                    ex_alu_op_o,
   output logic                          ex_use_imm_o,
   output logic                          ex_ovf_en_o,
   output logic                          taken_o,
   output logic [PC_W-1:0]               target_o,
   output logic                          dmem_rd_o,
   output logic                          dmem_wr_o,
   output logic                          rf_we_o,
   output logic [dsc_pkg::RA_W-1:0]      rf_waddr_o,
   output logic                          wb_sel_mem_o
);
   import dsc_pkg::*;

   localparam int EX = 0;
   localparam int MM = 1;
   localparam int WB = N_STG - 1;

   ctl_t              stg_q [N_STG];
   logic [PC_W-1:0]   ex_pc_q;
   logic signed [17:0] boff;

   generate
      for (genvar k = 0; k < N_STG; k++) begin : g_stg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else if (k == 0) stg_q[k] <= id_ctl_i;
            else stg_q[k] <= stg_q[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ex_pc_q <= '0;
      else        ex_pc_q <= id_pc_i;
   end

   // execute stage
   assign boff         = {stg_q[EX].off, 2'b00};
   assign target_o     = ex_pc_q + PC_W'(4) + PC_W'(boff);
   assign taken_o      = stg_q[EX].vld & stg_q[EX].is_br & br_eq_i;
   assign ex_alu_op_o  = stg_q[EX].alu;
   assign ex_use_imm_o = stg_q[EX].use_imm;
   assign ex_ovf_en_o  = stg_q[EX].vld & stg_q[EX].ovf_en;

   // memory stage: pass-through for ALU-class work
   assign dmem_rd_o = stg_q[MM].vld & stg_q[MM].mem_rd;
   assign dmem_wr_o = stg_q[MM].vld & stg_q[MM].mem_wr;

   // writeback stage: single write port, always stage 5
   assign rf_we_o      = stg_q[WB].vld & stg_q[WB].rf_we;
   assign rf_waddr_o   = stg_q[WB].dst;
   assign wb_sel_mem_o = stg_q[WB].vld & stg_q[WB].mem_rd;

   // R6: a store leaving memory never writes the register file
   p_store_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_wr_o |=> !rf_we_o);

   // R5: a load read in memory selects memory data in writeback
   p_load_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_rd_o |=> wb_sel_mem_o);

   // R4: memory stage never both reads and writes
   p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_rd_o && dmem_wr_o));

   generate
      if (ZERO_REG_FIXED) begin : g_zchk
         // R12: register 0 is never written
         p_no_zero_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
            rf_we_o |-> rf_waddr_o != '0);
      end
   endgenerate

endmodule

// File: rtl/dstat_pipe_ctl.sv
module dstat_pipe_ctl #(
   parameter int              PC_W           = 32,
   parameter logic [PC_W-1:0] RESET_PC       = '0,
   parameter bit              ZERO_REG_FIXED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     instr_i,
   input  logic            br_eq_i,
   output logic [PC_W-1:0] pc_o,
   output logic [4:0]      rf_ra_o,
   output logic [4:0]      rf_rb_o,
   output logic            id_squash_o,
   output logic [1:0]      ex_alu_op_o,
   output logic            ex_use_imm_o,
   output logic            ex_ovf_en_o,
   output logic            pc_sel_o,
   output logic            dmem_rd_o,
   output logic            dmem_wr_o,
   output logic            rf_we_o,
   output logic [4:0]      rf_waddr_o,
   output logic            wb_sel_mem_o
);
   import dsc_pkg::*;

   localparam int N_BACK = 3;   // execute, memory, writeback

   generate
      if (PC_W < 8 || PC_W > 64) begin : g_bad_pcw
         $error("dstat_pipe_ctl: PC_W out of range");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
         $error("dstat_pipe_ctl: RESET_PC must be word aligned");
      end
   endgenerate

   logic            fd_vld;
   logic [IW-1:0]   fd_instr;
   logic [PC_W-1:0] fd_pc;
   logic            fd_kill;
   logic            taken;
   logic [PC_W-1:0] target;
   ctl_t            id_ctl;

   dsc_fetch #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_i    (instr_i),
      .redirect_i (taken),
      .target_i   (target),
      .pc_o       (pc_o),
      .fd_vld_o   (fd_vld),
      .fd_instr_o (fd_instr),
      .fd_pc_o    (fd_pc),
      .fd_kill_o  (fd_kill)
   );

   dsc_decode #(.ZERO_REG_FIXED(ZERO_REG_FIXED)) u_decode (
      .vld_i   (fd_vld),
      .kill_i  (fd_kill),
      .instr_i (fd_instr),
      .ctl_o   (id_ctl)
   );

   dsc_stages #(.PC_W(PC_W), .ZERO_REG_FIXED(ZERO_REG_FIXED), .N_STG(N_BACK)) u_stages (
      .clk          (clk),
      .rst_n        (rst_n),
      .id_ctl_i     (id_ctl),
      .id_pc_i      (fd_pc),
      .br_eq_i      (br_eq_i),
      .ex_alu_op_o  (ex_alu_op_o),
      .ex_use_imm_o (ex_use_imm_o),
      .ex_ovf_en_o  (ex_ovf_en_o),
      .taken_o      (taken),
      .target_o     (target),
      .dmem_rd_o    (dmem_rd_o),
      .dmem_wr_o    (dmem_wr_o),
      .rf_we_o      (rf_we_o),
      .rf_waddr_o   (rf_waddr_o),
      .wb_sel_mem_o (wb_sel_mem_o)
   );

   assign rf_ra_o     = fd_instr[25:21];
   assign rf_rb_o     = fd_instr[20:16];
   assign id_squash_o = fd_vld & fd_kill;
   assign pc_sel_o    = taken;

   // R1: first cycle after reset release carries no strobe
   p_quiet_after_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rf_we_o && !dmem_rd_o && !dmem_wr_o && !pc_sel_o && pc_o == RESET_PC);

   // R11: squash marker follows a taken branch by one cycle
   p_squash_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel_o |=> id_squash_o);

   // R10: squashed instruction raises no overflow and no branch in execute
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_squash_o |=> !ex_ovf_en_o && !pc_sel_o);

   // R10: squashed instruction performs no memory write
   p_no_memwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_squash_o |-> ##2 !dmem_wr_o);

   // R10: squashed instruction performs no register write
   p_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_squash_o |-> ##3 !rf_we_o);

endmodule

// File: tb/dstat_pipe_ctl_tb_top.sv
module dstat_pipe_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RST_PC = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] instr_i;
   logic        br_eq_i;
   logic [31:0] pc_o;
   logic [4:0]  rf_ra_o, rf_rb_o, rf_waddr_o;
   logic        id_squash_o, ex_use_imm_o, ex_ovf_en_o, pc_sel_o;
   logic [1:0]  ex_alu_op_o;
   logic        dmem_rd_o, dmem_wr_o, rf_we_o, wb_sel_mem_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dstat_pipe_ctl #(.PC_W(32), .RESET_PC(RST_PC), .ZERO_REG_FIXED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .br_eq_i(br_eq_i),
      .pc_o(pc_o), .rf_ra_o(rf_ra_o), .rf_rb_o(rf_rb_o), .id_squash_o(id_squash_o),
      .ex_alu_op_o(ex_alu_op_o), .ex_use_imm_o(ex_use_imm_o), .ex_ovf_en_o(ex_ovf_en_o),
      .pc_sel_o(pc_sel_o), .dmem_rd_o(dmem_rd_o), .dmem_wr_o(dmem_wr_o),
      .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .wb_sel_mem_o(wb_sel_mem_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] imem [64];

   // model: index 1=decode, 2=execute, 3=memory, 4=writeback
   logic [31:0] m_pc;
   logic        m_redir;
   logic        s_vld  [1:4];
   logic [31:0] s_ins  [1:4];
   logic [31:0] s_pc   [1:4];
   logic        s_kill [1:4];
   logic        s_ds   [1:4];

   // packed view: {we, mrd, mwr, ovf, br, imm, alu[1:0], dst[4:0]}
   function automatic logic [12:0] dec(input logic [31:0] w);
      logic [5:0] c = w[31:26];
      logic [5:0] f = w[5:0];
      case (c)
         6'h00: case (f)
            6'h20: return {6'b100100, 2'd0, w[15:11]};
            6'h21: return {6'b100000, 2'd0, w[15:11]};
            6'h22: return {6'b100100, 2'd1, w[15:11]};
            6'h24: return {6'b100000, 2'd2, w[15:11]};
            6'h25: return {6'b100000, 2'd3, w[15:11]};
            default: return 13'd0;
         endcase
         6'h08: return {6'b100101, 2'd0, w[20:16]};
         6'h23: return {6'b110001, 2'd0, w[20:16]};
         6'h2B: return {6'b001001, 2'd0, 5'd0};
         6'h04: return {6'b000010, 2'd1, 5'd0};
         default: return 13'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int i);
      logic [4:0] a = 5'(i % 31 + 1);
      logic [4:0] b = 5'((i * 3) % 31);
      case (i % 11)
         0:  return {6'h00, a, b, 5'(i % 7 + 1), 5'd0, 6'h20};
         1:  return {6'h04, a, b, 16'(i % 5 - 2)};
         2:  return {6'h08, a, 5'(i % 8), 16'(i)};
         3:  return {6'h23, a, 5'(i % 6 + 1), 16'(i * 4)};
         4:  return {6'h2B, a, b, 16'(i * 8)};
         5:  return {6'h00, a, b, 5'(i % 4), 5'd0, 6'h22};
         6:  return {6'h04, a, b, 16'd3};
         7:  return {6'h00, a, b, 5'(i % 9 + 2), 5'd0, 6'h24};
         8:  return {6'h00, a, b, 5'(i % 5 + 3), 5'd0, 6'h25};
         9:  return {6'h00, a, b, 5'(i % 6 + 1), 5'd0, 6'h21};
         default: return (i % 2 == 0) ? {6'h04, a, b, 16'hFFFA} :
                                        ((i % 4 == 1) ? {6'h3F, a, b, 16'h1234}
                                                      : {6'h00, a, b, 5'd4, 5'd0, 6'h00});
      endcase
   endfunction

   task automatic m_reset();
      m_pc = RST_PC; m_redir = 0;
      for (int k = 1; k <= 4; k++) begin
         s_vld[k] = 0; s_ins[k] = 0; s_pc[k] = 0; s_kill[k] = 0; s_ds[k] = 0;
      end
   endtask

   task automatic step(input logic rst_v, input logic eq);
      logic [12:0] d2, d3, d4;
      logic tk, e_we, live2, live3, live4;
      logic [31:0] tgt, fetched;
      @(negedge clk);
      rst_n   = rst_v;
      br_eq_i = eq;
      fetched = imem[m_pc[7:2]];
      instr_i = fetched;
      #1;
      d2 = dec(s_ins[2]); d3 = dec(s_ins[3]); d4 = dec(s_ins[4]);
      live2 = s_vld[2] & !s_kill[2];
      live3 = s_vld[3] & !s_kill[3];
      live4 = s_vld[4] & !s_kill[4];
      tk = live2 & d2[8] & eq;
      if (!rst_v) begin
         chk("R1 pc", pc_o, RST_PC);
         chk("R1 rf_we", 32'(rf_we_o), 0);
         chk("R1 dmem_rd", 32'(dmem_rd_o), 0);
         chk("R1 dmem_wr", 32'(dmem_wr_o), 0);
         chk("R1 pc_sel", 32'(pc_sel_o), 0);
         chk("R1 ovf", 32'(ex_ovf_en_o), 0);
         chk("R1 squash", 32'(id_squash_o), 0);
         tk = 0;
      end else begin
         chk(m_redir ? "R8 pc target" : "R2 pc step", pc_o, m_pc);
         chk("R3 ra", 32'(rf_ra_o), 32'(s_ins[1][25:21]));
         chk("R3 rb", 32'(rf_rb_o), 32'(s_ins[1][20:16]));
         chk("R11 squash", 32'(id_squash_o), 32'(s_vld[1] & s_kill[1]));
         if (s_vld[2]) begin
            chk("R3 alu_op", 32'(ex_alu_op_o), 32'(d2[6:5]));
            chk("R3 use_imm", 32'(ex_use_imm_o), 32'(d2[7]));
         end
         chk(s_kill[2] ? "R10 ovf" : "R3 ovf", 32'(ex_ovf_en_o), 32'(live2 & d2[9]));
         chk(s_kill[2] ? "R10 pc_sel" : "R7 pc_sel", 32'(pc_sel_o), 32'(tk));
         chk(s_kill[3] ? "R10 dmem_rd" : "R5 dmem_rd", 32'(dmem_rd_o), 32'(live3 & d3[11]));
         chk(s_kill[3] ? "R10 dmem_wr" : "R6 dmem_wr", 32'(dmem_wr_o), 32'(live3 & d3[10]));
         e_we = live4 & d4[12] & (d4[4:0] != 0);
         if (s_kill[4])                      chk("R10 rf_we", 32'(rf_we_o), 32'(e_we));
         else if (s_ds[4])                   chk("R9 rf_we", 32'(rf_we_o), 32'(e_we));
         else if (d4[12] && d4[4:0] == 0)    chk("R12 rf_we", 32'(rf_we_o), 32'(e_we));
         else if (d4 == 0)                   chk("R13 rf_we", 32'(rf_we_o), 32'(e_we));
         else if (d4[10])                    chk("R6 rf_we", 32'(rf_we_o), 32'(e_we));
         else                                chk("R4 rf_we", 32'(rf_we_o), 32'(e_we));
         if (e_we) chk("R4 rf_waddr", 32'(rf_waddr_o), 32'(d4[4:0]));
         chk("R5 wb_sel_mem", 32'(wb_sel_mem_o), 32'(live4 & d4[11]));
      end
      tgt = s_pc[2] + 32'd4 + {{14{s_ins[2][15]}}, s_ins[2][15:0], 2'b00};
      @(posedge clk);
      if (!rst_v) m_reset();
      else begin
         for (int k = 4; k >= 2; k--) begin
            s_vld[k] = s_vld[k-1]; s_ins[k] = s_ins[k-1];
            s_pc[k] = s_pc[k-1]; s_kill[k] = s_kill[k-1]; s_ds[k] = s_ds[k-1];
         end
         s_ds[2]   = tk;
         s_vld[1]  = 1; s_ins[1] = fetched; s_pc[1] = m_pc; s_kill[1] = tk; s_ds[1] = 0;
         m_pc      = tk ? tgt : m_pc + 32'd4;
         m_redir   = tk;
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) imem[i] = mk(i);
      rst_n = 0; br_eq_i = 0; instr_i = 0;
      m_reset();
      for (int c = 0; c < 4; c++) step(0, 0);
      for (int c = 0; c < 900; c++) step(1, (c % 3) != 0);
      for (int c = 0; c < 400; c++) step(1, 1);
      for (int c = 0; c < 400; c++) step(1, 0);
      for (int c = 0; c < 3; c++) step(0, 1);
      for (int c = 0; c < 900; c++) step(1, (c % 5) < 2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule